// File: doc/BRIEF.md
# Receive Frame Filter and Ring Writer

This block sits on the receive side of an Ethernet controller. It takes an incoming frame one byte per cycle, decides from the destination address whether the station wants it, and stores accepted frames in a circular buffer made of 256-byte pages. The ring is bounded by a start page and a stop page. The write side starts at the current page. The reader's position is given by the boundary page.

Each stored frame begins on a page boundary with a four-byte header, and the frame data follows the header. Frames shorter than the minimum are padded with zeros. When a frame has been stored completely, the block reports the page at which the next frame will start, together with a receive status byte, and it pulses a completion flag that the surrounding logic folds into its interrupt status.

The first six bytes are held in a register until the filter has decided. They are written out after the end of the frame, along with any padding and the header. While this happens the block is busy, and a frame that begins during that time is dropped.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `busy`, `mem_we` and `rx_done` are 0, and `rx_status` and `new_page` read 0.
- R2: With `rx_mode[2]` (promiscuous) set, every frame is stored, whatever its destination.
- R3: When promiscuous mode is off, a destination of all ones is stored only when `rx_mode[0]` is set. Such a destination is never treated as a group address, so `rx_mode[1]` alone does not admit it.
- R4: When promiscuous mode is off, a destination other than all ones that has bit 0 of its first byte set is stored only when `rx_mode[1]` is set.
- R5: Any other destination is stored only when all six bytes equal `station_addr`, where the first byte on the wire is compared with `station_addr[7:0]`. Frame byte k of a stored frame lands at ring offset 4+k from the start of its first page.
- R6: A frame whose first byte arrives while `stopped` is high causes no memory write and no completion.
- R7: At the first byte, free space is (boundary − current) pages when current < boundary, and otherwise (stop − start) − (current − boundary) pages. One page is 256 bytes. When free space is below MAX_FRAME + 4 bytes, the frame is dropped without effect.
- R8: A frame of fewer than 60 bytes is stored padded with zero bytes to 60 bytes. The stored length is the padded length plus 4, and exactly that many bytes are written.
- R9: The header occupies offsets 0 to 3 of the frame's first page and holds, in this order: the status byte, the next-page number, the stored length low byte, and the stored length high byte.
- R10: The next page is current + floor((L + 8 + 255) / 256), where L is the padded length. If the result is at or beyond stop, (stop − start) is subtracted from it.
- R11: The status byte has bit 0 (received OK) always set, and bit 5 set when bit 0 of the first destination byte is 1. It appears on `rx_status` at completion.
- R12: A write address that reaches stop × 256 continues at start × 256.
- R13: Completion is a single-cycle pulse of `rx_done`, which coincides with the last header write and presents the next page on `new_page`. Every memory write happens while `busy` is high.
- R14: A frame whose first byte arrives while `busy` is high is dropped: it adds no writes and no completion, and a later frame is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | First byte of a frame |
| in_last | input | 1 | Last byte of a frame |
| rx_mode | input | 3 | Accept controls: bit 0 broadcast, bit 1 group, bit 2 promiscuous |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Page just past the ring |
| pg_bound | input | 8 | Boundary (reader) page |
| pg_cur | input | 8 | Current page where the next frame is stored |
| stopped | input | 1 | Controller stopped; frames are discarded |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | 16 | Ring memory byte address |
| mem_wdata | output | 8 | Ring memory write data |
| busy | output | 1 | A frame is in progress |
| rx_done | output | 1 | One-cycle completion pulse |
| new_page | output | 8 | Next current page, valid with `rx_done` |
| rx_status | output | 8 | Receive status of the last stored frame |

## Verification
The critical overlap is a new frame's first byte arriving in the same cycle that the block is still storing the padding, deferred address bytes or header of the previous frame. The bench provokes this by starting a second frame one cycle after the last byte of the first. It then judges the result on three points: the first frame must be stored exactly, with the exact write count; there must be a single completion pulse; and the second frame's bytes must appear nowhere. A third frame sent after `busy` falls must then be stored normally.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_SKIP,
        ST_PAD,
        ST_HEAD,
        ST_HDR
    } rxr_state_e;

    // rx_mode bit positions
    localparam int MODE_BCAST   = 0;
    localparam int MODE_GROUP   = 1;
    localparam int MODE_PROMISC = 2;

    // status byte bit positions
    localparam int STAT_OK    = 0;
    localparam int STAT_GROUP = 5;

    localparam int HDR_BYTES  = 4;

endpackage

// File: rtl/rxr_addr_filter.sv
module rxr_addr_filter
    import rxr_pkg::*;
#(
    parameter int MAC_BYTES = 6
) (
    input  logic [8*MAC_BYTES-1:0] dst_addr,
    input  logic [8*MAC_BYTES-1:0] station,
    input  logic [2:0]             mode,
    output logic                   accept,
    output logic                   group_hit
);
    logic all_ones;

    always_comb begin
        all_ones  = &dst_addr;
        group_hit = dst_addr[0];
        if (mode[MODE_PROMISC]) begin
            accept = 1'b1;
        end else if (all_ones) begin
            accept = mode[MODE_BCAST];
        end else if (group_hit) begin
            accept = mode[MODE_GROUP];
        end else begin
            accept = (dst_addr == station);
        end
    end

endmodule

// File: rtl/rxr_space_check.sv
module rxr_space_check #(
    parameter int PAGE_W    = 8,
    parameter int MAX_FRAME = 1514
) (
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] bound_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic              full
);
    localparam int SP_W = PAGE_W + 9;

    logic [SP_W-1:0] free_pg;
    logic [SP_W-1:0] free_bytes;

    always_comb begin
        if (cur_pg < bound_pg) begin
            free_pg = SP_W'(bound_pg) - SP_W'(cur_pg);
        end else begin
            free_pg = (SP_W'(stop_pg) - SP_W'(start_pg)) - (SP_W'(cur_pg) - SP_W'(bound_pg));
        end
        free_bytes = free_pg << 8;
        full       = free_bytes < SP_W'(MAX_FRAME + 4);
    end

endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [PAGE_W-1:0] base_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [LEN_W-1:0]  data_len,
    output logic [PAGE_W-1:0] next_pg
);
    localparam int NP_W = (LEN_W > PAGE_W ? LEN_W : PAGE_W) + 2;

    logic [NP_W-1:0] span;
    logic [NP_W-1:0] raw;

    always_comb begin
        span = (NP_W'(data_len) + NP_W'(8 + 255)) >> 8;
        raw  = NP_W'(base_pg) + span;
        if (raw >= NP_W'(stop_pg)) begin
            raw = raw - (NP_W'(stop_pg) - NP_W'(start_pg));
        end
        next_pg = PAGE_W'(raw);
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int MAC_BYTES = 6,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60,
    parameter int LEN_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    input  logic                   in_first,
    input  logic                   in_last,
    input  logic [2:0]             rx_mode,
    input  logic [8*MAC_BYTES-1:0] station_addr,
    input  logic [PAGE_W-1:0]      pg_start,
    input  logic [PAGE_W-1:0]      pg_stop,
    input  logic [PAGE_W-1:0]      pg_bound,
    input  logic [PAGE_W-1:0]      pg_cur,
    input  logic                   stopped,
    output logic                   mem_we,
    output logic [PAGE_W+7:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    output logic                   busy,
    output logic                   rx_done,
    output logic [PAGE_W-1:0]      new_page,
    output logic [7:0]             rx_status
);
    localparam int ADDR_W = PAGE_W + 8;
    localparam int MAC_W  = 8 * MAC_BYTES;
    localparam int HK_MAX = (MAC_BYTES > HDR_BYTES) ? MAC_BYTES : HDR_BYTES;
    localparam int HK_W   = $clog2(HK_MAX);

    typedef struct packed {
        rxr_state_e        state;
        logic [LEN_W-1:0]  pos;
        logic [MAC_W-1:0]  dst;
        logic              grp;
        logic [ADDR_W-1:0] wptr;
        logic [PAGE_W-1:0] base_pg;
        logic [PAGE_W-1:0] start_pg;
        logic [PAGE_W-1:0] stop_pg;
        logic [HK_W-1:0]   hk;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic              busy;
        logic              done;
        logic [PAGE_W-1:0] npg;
        logic [7:0]        status;
    } regs_t;

    regs_t r_q, r_d;

    logic              starting;
    logic [LEN_W-1:0]  p;
    logic [MAC_W-1:0]  dst_in;
    logic              accept;
    logic              grp_hit;
    logic              ring_full;
    logic [PAGE_W-1:0] next_pg;
    logic [7:0]        stat_byte;
    logic [LEN_W-1:0]  stored_len;

    function automatic logic [ADDR_W-1:0] ring_step(
        input logic [ADDR_W-1:0] a,
        input logic [PAGE_W-1:0] s_pg,
        input logic [PAGE_W-1:0] e_pg
    );
        logic [ADDR_W-1:0] n;
        n = a + ADDR_W'(1);
        if (n == {e_pg, 8'h00}) begin
            n = {s_pg, 8'h00};
        end
        return n;
    endfunction

    // byte position and destination register with the incoming byte merged
    always_comb begin
        starting = in_valid && in_first && (r_q.state == ST_IDLE) && !r_q.busy;
        p        = starting ? '0 : r_q.pos;
        dst_in   = starting ? '0 : r_q.dst;
        for (int k = 0; k < MAC_BYTES; k++) begin
            if (p == LEN_W'(k)) begin
                dst_in[8*k +: 8] = in_data;
            end
        end
    end

    rxr_addr_filter #(
        .MAC_BYTES (MAC_BYTES)
    ) u_filter (
        .dst_addr  (dst_in),
        .station   (station_addr),
        .mode      (rx_mode),
        .accept    (accept),
        .group_hit (grp_hit)
    );

    rxr_space_check #(
        .PAGE_W    (PAGE_W),
        .MAX_FRAME (MAX_FRAME)
    ) u_space (
        .cur_pg   (pg_cur),
        .bound_pg (pg_bound),
        .start_pg (pg_start),
        .stop_pg  (pg_stop),
        .full     (ring_full)
    );

    rxr_next_page #(
        .PAGE_W (PAGE_W),
        .LEN_W  (LEN_W)
    ) u_next (
        .base_pg  (r_q.base_pg),
        .start_pg (r_q.start_pg),
        .stop_pg  (r_q.stop_pg),
        .data_len (r_q.pos),
        .next_pg  (next_pg)
    );

    always_comb begin
        stat_byte  = 8'(1 << STAT_OK) | (r_q.grp ? 8'(1 << STAT_GROUP) : 8'h00);
        stored_len = r_q.pos + LEN_W'(HDR_BYTES);
    end

    always_comb begin
        r_d       = r_q;
        r_d.we    = 1'b0;
        r_d.wdata = '0;
        r_d.done  = 1'b0;

        if (starting) begin
            r_d.base_pg  = pg_cur;
            r_d.start_pg = pg_start;
            r_d.stop_pg  = pg_stop;
            r_d.grp      = 1'b0;
            r_d.pos      = '0;
            r_d.dst      = '0;
            r_d.wptr     = {pg_cur, 8'h00} + ADDR_W'(HDR_BYTES + MAC_BYTES);
        end

        if (starting && (stopped || ring_full)) begin
            r_d.state = in_last ? ST_IDLE : ST_SKIP;
        end else if (starting || (r_q.state == ST_RECV && in_valid)) begin
            r_d.dst = dst_in;
            if (p >= LEN_W'(MAC_BYTES)) begin
                r_d.we    = 1'b1;
                r_d.addr  = r_q.wptr;
                r_d.wdata = in_data;
                r_d.wptr  = ring_step(r_q.wptr, r_q.start_pg, r_q.stop_pg);
                r_d.pos   = p + LEN_W'(1);
                if (in_last) begin
                    r_d.state = ST_PAD;
                end
            end else if (p == LEN_W'(MAC_BYTES - 1) || in_last) begin
                if (!accept) begin
                    r_d.state = in_last ? ST_IDLE : ST_SKIP;
                end else begin
                    r_d.grp   = grp_hit;
                    r_d.pos   = LEN_W'(MAC_BYTES);
                    r_d.state = in_last ? ST_PAD : ST_RECV;
                end
            end else begin
                r_d.pos   = p + LEN_W'(1);
                r_d.state = ST_RECV;
            end
        end else begin
            case (r_q.state)
                ST_SKIP: begin
                    if (in_valid && in_last) begin
                        r_d.state = ST_IDLE;
                    end
                end
                ST_PAD: begin
                    if (r_q.pos < LEN_W'(MIN_FRAME)) begin
                        r_d.we    = 1'b1;
                        r_d.addr  = r_q.wptr;
                        r_d.wdata = 8'h00;
                        r_d.wptr  = ring_step(r_q.wptr, r_q.start_pg, r_q.stop_pg);
                        r_d.pos   = r_q.pos + LEN_W'(1);
                    end else begin
                        r_d.state = ST_HEAD;
                        r_d.hk    = '0;
                    end
                end
                ST_HEAD: begin
                    r_d.we   = 1'b1;
                    r_d.addr = {r_q.base_pg, 8'h00} + ADDR_W'(HDR_BYTES) + ADDR_W'(r_q.hk);
                    for (int k = 0; k < MAC_BYTES; k++) begin
                        if (r_q.hk == HK_W'(k)) begin
                            r_d.wdata = r_q.dst[8*k +: 8];
                        end
                    end
                    if (r_q.hk == HK_W'(MAC_BYTES - 1)) begin
                        r_d.state = ST_HDR;
                        r_d.hk    = '0;
                    end else begin
                        r_d.hk = r_q.hk + HK_W'(1);
                    end
                end
                ST_HDR: begin
                    r_d.we   = 1'b1;
                    r_d.addr = {r_q.base_pg, 8'h00} + ADDR_W'(r_q.hk);
                    r_d.hk   = r_q.hk + HK_W'(1);
                    case (r_q.hk)
                        HK_W'(0): r_d.wdata = stat_byte;
                        HK_W'(1): r_d.wdata = next_pg;
                        HK_W'(2): r_d.wdata = 8'(stored_len);
                        default: begin
                            r_d.wdata  = 8'(stored_len >> 8);
                            r_d.done   = 1'b1;
                            r_d.npg    = next_pg;
                            r_d.status = stat_byte;
                            r_d.state  = ST_IDLE;
                        end
                    endcase
                end
                default: ;
            endcase
        end

        r_d.busy = (r_d.state != ST_IDLE) || r_d.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign busy      = r_q.busy;
    assign rx_done   = r_q.done;
    assign new_page  = r_q.npg;
    assign rx_status = r_q.status;

endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rx_done,
    input logic [PAGE_W-1:0] new_page,
    input logic              status_ok,
    input logic [PAGE_W-1:0] pg_start,
    input logic [PAGE_W-1:0] pg_stop
);
    // R13
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R13
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R11
    status_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> status_ok);

    // R12
    addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= {pg_start, 8'h00}) && (mem_addr < {pg_stop, 8'h00}));

    // R10
    next_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (new_page >= pg_start) && (new_page < pg_stop));

endmodule

bind rx_ring_writer rxr_chk #(
    .PAGE_W (PAGE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .rx_done   (rx_done),
    .new_page  (new_page),
    .status_ok (rx_status[0]),
    .pg_start  (pg_start),
    .pg_stop   (pg_stop)
);

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;

    localparam logic [47:0] STA = {8'h56, 8'h34, 8'h12, 8'h00, 8'h54, 8'h52};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic [2:0]  rx_mode = 3'b000;
    logic [47:0] station_addr = STA;
    logic [7:0]  pg_start = 8'h40;
    logic [7:0]  pg_stop = 8'h60;
    logic [7:0]  pg_bound = 8'h40;
    logic [7:0]  pg_cur = 8'h46;
    logic        stopped = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        busy;
    logic        rx_done;
    logic [7:0]  new_page;
    logic [7:0]  rx_status;

    int total = 0;
    int fails = 0;
    int wcount = 0;
    int dcount = 0;
    logic [7:0] last_np = 8'h00;
    logic [7:0] last_st = 8'h00;
    logic [7:0] wlog [int];

    always #2 clk = ~clk;

    rx_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .rx_mode(rx_mode),
        .station_addr(station_addr), .pg_start(pg_start), .pg_stop(pg_stop),
        .pg_bound(pg_bound), .pg_cur(pg_cur), .stopped(stopped),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .rx_done(rx_done), .new_page(new_page), .rx_status(rx_status)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                wlog[int'(mem_addr)] = mem_wdata;
                wcount++;
            end
            if (rx_done) begin
                dcount++;
                last_np = new_page;
                last_st = rx_status;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [47:0] d, input int k, input int seed);
        if (k < 6) return d[8*k +: 8];
        return 8'(seed + 7 * k);
    endfunction

    task automatic clear_log();
        wlog.delete();
        wcount = 0;
        dcount = 0;
    endtask

    task automatic send(input logic [47:0] d, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fbyte(d, i, seed);
            in_first = (i == 0);
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic expect_dropped(input string tag);
        check(wcount == 0, tag, "write count of dropped frame", wcount, 0);
        check(dcount == 0, tag, "completions of dropped frame", dcount, 0);
    endtask

    task automatic expect_stored(input string tag, input logic [47:0] d, input int n,
                                 input int seed, input int base, input int st, input int sp);
        int len_p = (n < 60) ? 60 : n;
        int slen = len_p + 4;
        int nxt = base + ((len_p + 8 + 255) >> 8);
        int stat = d[0] ? 8'h21 : 8'h01;
        int bad = 0;
        int bad_a = 0;
        int bad_v = 0;
        int bad_e = 0;
        if (nxt >= sp) nxt = nxt - (sp - st);
        check(dcount == 1, "R13", "completion pulses", dcount, 1);
        check(int'(last_np) == nxt, "R10", "new page", last_np, nxt);
        check(int'(last_st) == stat, "R11", "status output", last_st, stat);
        check(wcount == slen, "R8", "bytes written", wcount, slen);
        for (int h = 0; h < 4; h++) begin
            int a = base * 256 + h;
            int e = (h == 0) ? stat : (h == 1) ? nxt : (h == 2) ? (slen & 255) : (slen >> 8);
            int v = wlog.exists(a) ? int'(wlog[a]) : -1;
            check(v == e, "R9", "header byte", v, e);
        end
        for (int k = 0; k < len_p; k++) begin
            int a = base * 256 + 4 + k;
            int e = (k < n) ? int'(fbyte(d, k, seed)) : 0;
            int v;
            if (a >= sp * 256) a = a - (sp - st) * 256;
            v = wlog.exists(a) ? int'(wlog[a]) : -1;
            if (v != e && bad == 0) begin
                bad_a = a;
                bad_v = v;
                bad_e = e;
            end
            if (v != e) bad++;
        end
        check(bad == 0, tag, $sformatf("frame data at %0h", bad_a), bad_v, bad_e);
    endtask

    task automatic set_ring(input int st, input int sp, input int bd, input int cu);
        pg_start = 8'(st);
        pg_stop  = 8'(sp);
        pg_bound = 8'(bd);
        pg_cur   = 8'(cu);
    endtask

    task automatic frame_case(input string tag, input logic [47:0] d, input int n,
                              input int seed, input bit keep);
        clear_log();
        send(d, n, seed);
        wait_idle();
        if (keep) expect_stored(tag, d, n, seed, int'(pg_cur), int'(pg_start), int'(pg_stop));
        else expect_dropped(tag);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
        check(rx_done == 1'b0, "R1", "rx_done after reset", rx_done, 0);
        check(rx_status == 8'h00, "R1", "rx_status after reset", rx_status, 0);
        check(new_page == 8'h00, "R1", "new_page after reset", new_page, 0);
    endtask

    task automatic t_unicast();
        rx_mode = 3'b000;
        set_ring(8'h40, 8'h60, 8'h40, 8'h46);
        frame_case("R5", STA, 100, 3, 1'b1);
        frame_case("R5", {8'h57, STA[39:0]}, 100, 4, 1'b0);
        frame_case("R5", {STA[47:8], 8'h50}, 100, 5, 1'b0);
    endtask

    task automatic t_broadcast();
        rx_mode = 3'b000;
        frame_case("R3", 48'hffff_ffff_ffff, 80, 6, 1'b0);
        rx_mode = 3'b010;
        frame_case("R3", 48'hffff_ffff_ffff, 80, 7, 1'b0);
        rx_mode = 3'b001;
        frame_case("R3", 48'hffff_ffff_ffff, 80, 8, 1'b1);
    endtask

    task automatic t_group();
        rx_mode = 3'b000;
        frame_case("R4", 48'h0100_5e00_0001, 90, 9, 1'b0);
        rx_mode = 3'b001;
        frame_case("R4", 48'h0100_5e00_0001, 90, 10, 1'b0);
        rx_mode = 3'b010;
        frame_case("R4", 48'h0100_5e00_0001, 90, 11, 1'b1);
    endtask

    task automatic t_promisc();
        rx_mode = 3'b100;
        frame_case("R2", 48'h0a0b_0c0d_0e02, 70, 12, 1'b1);
        frame_case("R2", 48'h0100_5e00_0003, 70, 13, 1'b1);
    endtask

    task automatic t_short();
        rx_mode = 3'b100;
        frame_case("R8", 48'h0a0b_0c0d_0e02, 20, 14, 1'b1);
        frame_case("R8", 48'h0a0b_0c0d_0e04, 3, 15, 1'b1);
        frame_case("R8", 48'h0a0b_0c0d_0e06, 60, 16, 1'b1);
    endtask

    task automatic t_nextpage();
        rx_mode = 3'b100;
        frame_case("R10", 48'h0a0b_0c0d_0e02, 248, 17, 1'b1);
        frame_case("R10", 48'h0a0b_0c0d_0e02, 249, 18, 1'b1);
    endtask

    task automatic t_wrap();
        rx_mode = 3'b100;
        set_ring(8'h40, 8'h50, 8'h48, 8'h4f);
        frame_case("R12", 48'h0a0b_0c0d_0e02, 300, 19, 1'b1);
        set_ring(8'h40, 8'h60, 8'h40, 8'h46);
    endtask

    task automatic t_full();
        rx_mode = 3'b100;
        set_ring(8'h40, 8'h60, 8'h49, 8'h43);
        frame_case("R7", 48'h0a0b_0c0d_0e02, 100, 20, 1'b1);
        set_ring(8'h40, 8'h60, 8'h49, 8'h44);
        frame_case("R7", 48'h0a0b_0c0d_0e02, 100, 21, 1'b0);
        set_ring(8'h40, 8'h60, 8'h41, 8'h5c);
        frame_case("R7", 48'h0a0b_0c0d_0e02, 100, 22, 1'b0);
        set_ring(8'h40, 8'h60, 8'h48, 8'h49);
        frame_case("R7", 48'h0a0b_0c0d_0e02, 100, 23, 1'b1);
        set_ring(8'h40, 8'h60, 8'h40, 8'h46);
    endtask

    task automatic t_stopped();
        rx_mode = 3'b100;
        stopped = 1'b1;
        frame_case("R6", 48'h0a0b_0c0d_0e02, 64, 24, 1'b0);
        stopped = 1'b0;
        frame_case("R6", 48'h0a0b_0c0d_0e02, 64, 25, 1'b1);
    endtask

    task automatic t_busy();
        rx_mode = 3'b100;
        clear_log();
        send(48'h0a0b_0c0d_0e02, 80, 26);
        check(busy == 1'b1, "R14", "busy after last byte", busy, 1);
        send(48'h0a0b_0c0d_0e08, 80, 27);
        wait_idle();
        expect_stored("R14", 48'h0a0b_0c0d_0e02, 80, 26, int'(pg_cur), int'(pg_start), int'(pg_stop));
        frame_case("R14", 48'h0a0b_0c0d_0e0a, 90, 28, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: run did not finish, got 1 expected 0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_broadcast();
        t_group();
        t_promisc();
        t_short();
        t_nextpage();
        t_wrap();
        t_full();
        t_stopped();
        t_busy();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule